// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a free-running tick counter and a compare register beside it. The counter advances by one on every cycle in which the tick enable is high. When an armed compare value is reached or passed, the block emits a one-cycle match pulse. That pulse sets a soft-interrupt bit and also serves as the wake request for a halted core.

The top bit of each written word is a flag, not part of the number. On a count write it sets a "non-privileged trap" flag, which reads back as bit 63 of the count. On a compare write it sets an interrupt-disable flag. A compare write with a zero value, or with the disable flag set, leaves the timer unarmed. A compare value that is already behind the count fires on the very next tick, so it is never lost.

A parameter selects the soft-interrupt bit a match drives: the tick bit (index 0) or the system-tick bit (index 1).

Top module: `tick_compare_timer`

## Requirements
- R1: A count write loads bits 62:0 as the counter value and bit 63 as the trap flag. The read port then returns the 63-bit value, with bit 63 equal to the trap flag.
- R2: In a cycle with the tick enable high and no count write, the counter increments by one. It wraps from 0x7FFF_FFFF_FFFF_FFFF to 0.
- R3: A compare write with bit 63 clear and a non-zero value in bits 62:0 arms the timer against that value. This holds even right after a disabled write.
- R4: A compare write with zero in bits 62:0 leaves the timer unarmed, and no match pulse follows.
- R5: A compare write with bit 63 set (disable) leaves the timer unarmed, and no match pulse follows.
- R6: While armed, a tick cycle whose pre-increment count is greater than or equal to the compare value raises the match pulse for exactly one cycle, starting at the next clock edge. A compare value already behind the count therefore fires on the first tick after the write.
- R7: A match disarms the timer. Only a new compare write can produce another match.
- R8: After reset the count reads 0x8000_0000_0000_0000 (value 0, trap flag set), the timer is disabled, and the match pulse is low.
- R9: `softSet` equals the match pulse on bit SOFT_SEL (0 = tick bit, 1 = system-tick bit). The other bit stays 0.
- R10: A tick cycle that coincides with a count write or a compare write produces no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tickEn | input | 1 | Counter advances in this cycle |
| cntWrEn | input | 1 | Count write strobe |
| cntWrData | input | 64 | Count write word; bit 63 is the trap flag |
| limWrEn | input | 1 | Compare write strobe |
| limWrData | input | 64 | Compare write word; bit 63 is the disable flag |
| cntRdData | output | 64 | Live count; bit 63 is the trap flag |
| matchPulse | output | 1 | One-cycle match pulse, also the wake request |
| softSet | output | 2 | Soft-interrupt set pulses: bit 0 tick, bit 1 system tick |

## Verification
The compare path is driven with several patterns. An ordinary forward approach to the compare value shows that the pulse comes at the right cycle and only once. A compare value already behind the count separates "fire on the next tick" from "lost until wrap". Zero and disabled compare writes check that neither arms the timer. A tick that coincides with a write checks that the write takes priority. The counter is also run across its 63-bit wrap, and the trap flag is toggled, to show that the flag and the value stay apart.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;
  typedef struct packed {
    logic loadCnt;
    logic incCnt;
    logic loadLim;
  } tickStrobe_t;
endpackage

// File: rtl/tick_cmp_dp.sv
module tick_cmp_dp
  import tick_cmp_pkg::*;
#(
  parameter int VAL_W = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tickStrobe_t      strb,
  input  logic [VAL_W-1:0] cntWrVal,
  input  logic [VAL_W-1:0] limWrVal,
  input  logic             nptFlag,
  output logic             cntGeLim,
  output logic             limWrZero,
  output logic [VAL_W:0]   cntRdData
);
  logic [VAL_W-1:0] cntQ;
  logic [VAL_W-1:0] limQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ <= '0;
    end else if (strb.loadCnt) begin
      cntQ <= cntWrVal;
    end else if (strb.incCnt) begin
      cntQ <= cntQ + VAL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limQ <= '0;
    end else if (strb.loadLim) begin
      limQ <= limWrVal;
    end
  end

  assign cntGeLim  = (cntQ >= limQ);
  assign limWrZero = (limWrVal == '0);
  assign cntRdData = {nptFlag, cntQ};
endmodule

// File: rtl/tick_cmp_ctrl.sv
module tick_cmp_ctrl
  import tick_cmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tickEn,
  input  logic        cntWrEn,
  input  logic        cntWrFlag,
  input  logic        limWrEn,
  input  logic        limWrFlag,
  input  logic        limWrZero,
  input  logic        cntGeLim,
  output tickStrobe_t strb,
  output logic        nptFlag,
  output logic        matchPulse
);
  logic armedQ;
  logic disQ;
  logic nptQ;
  logic matchQ;
  logic matchNow;

  always_comb begin
    strb.loadCnt = cntWrEn;
    strb.incCnt  = tickEn && !cntWrEn;
    strb.loadLim = limWrEn;
  end

  // a write in the same cycle as a tick takes priority over the compare
  assign matchNow = armedQ && !disQ && tickEn && !cntWrEn && !limWrEn && cntGeLim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armedQ <= 1'b0;
      disQ   <= 1'b1;
      nptQ   <= 1'b1;
      matchQ <= 1'b0;
    end else begin
      matchQ <= matchNow;
      if (cntWrEn) nptQ <= cntWrFlag;
      if (limWrEn) begin
        disQ   <= limWrFlag;
        armedQ <= !limWrFlag && !limWrZero;
      end else if (matchNow) begin
        armedQ <= 1'b0;
      end
    end
  end

  assign nptFlag    = nptQ;
  assign matchPulse = matchQ;
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer
  import tick_cmp_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int SOFT_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             limWrEn,
  input  logic [CNT_W-1:0] limWrData,
  output logic [CNT_W-1:0] cntRdData,
  output logic             matchPulse,
  output logic [1:0]       softSet
);
  localparam int VAL_W = CNT_W - 1;

  tickStrobe_t strb;
  logic        nptFlag;
  logic        cntGeLim;
  logic        limWrZero;

  tick_cmp_ctrl ctrlI (
    .clk        (clk),
    .rst_n      (rst_n),
    .tickEn     (tickEn),
    .cntWrEn    (cntWrEn),
    .cntWrFlag  (cntWrData[VAL_W]),
    .limWrEn    (limWrEn),
    .limWrFlag  (limWrData[VAL_W]),
    .limWrZero  (limWrZero),
    .cntGeLim   (cntGeLim),
    .strb       (strb),
    .nptFlag    (nptFlag),
    .matchPulse (matchPulse)
  );

  tick_cmp_dp #(.VAL_W(VAL_W)) dpI (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .cntWrVal  (cntWrData[VAL_W-1:0]),
    .limWrVal  (limWrData[VAL_W-1:0]),
    .nptFlag   (nptFlag),
    .cntGeLim  (cntGeLim),
    .limWrZero (limWrZero),
    .cntRdData (cntRdData)
  );

  generate
    if (SOFT_SEL == 1) begin : g_stick
      assign softSet = {matchPulse, 1'b0};
    end else begin : g_tick
      assign softSet = {1'b0, matchPulse};
    end
  endgenerate
endmodule

// File: rtl/tick_compare_chk.sv
module tick_compare_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tickEn,
  input logic             cntWrEn,
  input logic [CNT_W-1:0] cntWrData,
  input logic             limWrEn,
  input logic [CNT_W-1:0] limWrData,
  input logic [CNT_W-1:0] cntRdData,
  input logic             matchPulse,
  input logic [1:0]       softSet
);
  localparam int VAL_W = CNT_W - 1;

  logic quietQ;
  logic firedQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quietQ <= 1'b1;
      firedQ <= 1'b0;
    end else begin
      if (limWrEn) quietQ <= limWrData[VAL_W] || (limWrData[VAL_W-1:0] == '0);
      if (limWrEn) firedQ <= 1'b0;
      else if (matchPulse) firedQ <= 1'b1;
    end
  end

  // R1
  npt_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cntWrEn |=> cntRdData[VAL_W] == $past(cntWrData[VAL_W]));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && !cntWrEn) |=> cntRdData[VAL_W-1:0] == VAL_W'($past(cntRdData[VAL_W-1:0]) + VAL_W'(1)));
  // R4
  quiet_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quietQ |-> !matchPulse);
  // R7
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    matchPulse |-> !firedQ);
  // R10
  write_blocks_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cntWrEn || limWrEn) |=> !matchPulse);
  // R9
  soft_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(softSet) && ((softSet != 2'b00) == matchPulse));
  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    matchPulse |=> !matchPulse);
endmodule

bind tick_compare_timer tick_compare_chk #(.CNT_W(CNT_W)) chkI (
  .clk        (clk),
  .rst_n      (rst_n),
  .tickEn     (tickEn),
  .cntWrEn    (cntWrEn),
  .cntWrData  (cntWrData),
  .limWrEn    (limWrEn),
  .limWrData  (limWrData),
  .cntRdData  (cntRdData),
  .matchPulse (matchPulse),
  .softSet    (softSet)
);

// File: tb/tick_compare_timer_test.sv
module tick_compare_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tickEn = 1'b0;
  logic        cntWrEn = 1'b0;
  logic [63:0] cntWrData = '0;
  logic        limWrEn = 1'b0;
  logic [63:0] limWrData = '0;
  logic [63:0] cntRdData;
  logic        matchPulse;
  logic [1:0]  softSet;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  // reference model state
  longint unsigned mCnt = 0;
  longint unsigned mLim = 0;
  bit mNpt = 1'b1;
  bit mArmed = 1'b0;
  bit mPulse = 1'b0;

  always #10 clk = ~clk;

  tick_compare_timer uut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .cntWrEn(cntWrEn),
    .cntWrData(cntWrData), .limWrEn(limWrEn), .limWrData(limWrData),
    .cntRdData(cntRdData), .matchPulse(matchPulse), .softSet(softSet)
  );

  localparam longint unsigned MASK63 = 64'h7FFF_FFFF_FFFF_FFFF;

  always @(posedge clk) begin
    bit fire;
    if (!rst_n) begin
      mCnt = 0; mLim = 0; mNpt = 1'b1; mArmed = 1'b0; mPulse = 1'b0;
    end else begin
      fire = mArmed && tickEn && !cntWrEn && !limWrEn && (mCnt >= mLim);
      mPulse = fire;
      if (limWrEn) begin
        mLim = limWrData & MASK63;
        mArmed = !limWrData[63] && ((limWrData & MASK63) != 0);
      end else if (fire) mArmed = 1'b0;
      if (cntWrEn) begin
        mCnt = cntWrData & MASK63;
        mNpt = cntWrData[63];
      end else if (tickEn) mCnt = (mCnt + 1) & MASK63;
    end
  end

  task automatic check(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cntRdData == {mNpt, mCnt[62:0]}, "R1/R2 count read", cntRdData, {mNpt, mCnt[62:0]});
      check(matchPulse == mPulse, "R6 match timing", matchPulse, mPulse);
      check(softSet == {1'b0, mPulse}, "R9 soft bit", softSet, {1'b0, mPulse});
      if (matchPulse) pulses++;
    end
  end

  task automatic cyc(input bit tk, input bit cw, input logic [63:0] cd,
                     input bit lw, input logic [63:0] ld);
    @(posedge clk);
    #5;
    tickEn = tk; cntWrEn = cw; cntWrData = cd; limWrEn = lw; limWrData = ld;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int p0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check(cntRdData == 64'h8000_0000_0000_0000, "R8 reset count", cntRdData, 64'h8000_0000_0000_0000);
    check(matchPulse == 1'b0, "R8 reset pulse", matchPulse, 0);
    // R8: disabled after reset, ticks raise nothing
    p0 = pulses; ticks(20); idle(2); @(negedge clk);
    check(pulses == p0, "R8 disabled after reset", pulses - p0, 0);

    // R1: count writes with and without the trap flag
    cyc(1'b0, 1'b1, 64'h0000_0000_0000_0010, 1'b0, '0); idle(1); @(negedge clk);
    check(cntRdData == 64'h10, "R1 write flag clear", cntRdData, 64'h10);
    cyc(1'b0, 1'b1, 64'h8000_0000_0000_0005, 1'b0, '0); idle(1); @(negedge clk);
    check(cntRdData == 64'h8000_0000_0000_0005, "R1 write flag set", cntRdData, 64'h8000_0000_0000_0005);

    // R2: increment and wrap
    ticks(3); idle(1); @(negedge clk);
    check(cntRdData == 64'h8000_0000_0000_0008, "R2 increment", cntRdData, 64'h8000_0000_0000_0008);
    cyc(1'b0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFE, 1'b0, '0); ticks(2); idle(1); @(negedge clk);
    check(cntRdData == 64'h0, "R2 wrap", cntRdData, 64'h0);

    // R4: zero compare never arms
    p0 = pulses;
    cyc(1'b0, 1'b0, '0, 1'b1, 64'h0); ticks(10); idle(2); @(negedge clk);
    check(pulses == p0, "R4 zero compare", pulses - p0, 0);

    // R5: disabled compare never arms
    p0 = pulses;
    cyc(1'b0, 1'b0, '0, 1'b1, 64'h8000_0000_0000_0003); ticks(10); idle(2); @(negedge clk);
    check(pulses == p0, "R5 disabled compare", pulses - p0, 0);

    // R3 / R6 / R7: forward approach, one pulse only
    p0 = pulses;
    cyc(1'b0, 1'b1, 64'h0, 1'b1, 64'h4); ticks(12); idle(2); @(negedge clk);
    check(pulses - p0 == 1, "R3 R7 single match", pulses - p0, 1);

    // R6: compare already behind the count fires on the first tick
    p0 = pulses;
    cyc(1'b0, 1'b1, 64'd100, 1'b1, 64'd10); ticks(1); idle(1); @(negedge clk);
    check(matchPulse == 1'b1, "R6 past compare fires", matchPulse, 1);
    idle(2); @(negedge clk);
    check(pulses - p0 == 1, "R6 past compare count", pulses - p0, 1);

    // R10: tick coinciding with a count write, then a compare write, yields no match
    p0 = pulses;
    cyc(1'b0, 1'b0, '0, 1'b1, 64'd5); idle(1);
    cyc(1'b1, 1'b1, 64'd10, 1'b0, '0); idle(2); @(negedge clk);
    check(pulses == p0, "R10 tick with count write", pulses - p0, 0);
    cyc(1'b1, 1'b0, '0, 1'b1, 64'd5); idle(2); @(negedge clk);
    check(pulses == p0, "R10 tick with compare write", pulses - p0, 0);
    ticks(1); idle(2); @(negedge clk);
    check(pulses - p0 == 1, "R10 later tick matches", pulses - p0, 1);

    // R3: re-arming after a disable write
    p0 = pulses;
    cyc(1'b0, 1'b1, 64'd0, 1'b1, 64'h8000_0000_0000_0002); ticks(5);
    cyc(1'b0, 1'b0, '0, 1'b1, 64'd7); ticks(10); idle(2); @(negedge clk);
    check(pulses - p0 == 1, "R3 re-arm after disable", pulses - p0, 1);

    idle(2);
    finish_run();
  end
endmodule